// File: doc/BRIEF.md
# Framed Byte-Stream to AXI-Stream Bridge

This block connects a byte-wide packet source and sink to an AXI-Stream MAC backend. The source side frames packets with a first-byte strobe and a last-byte strobe. On the way out, each framed byte becomes one AXI-Stream beat. The first-byte strobe rides on TUSER, and the last-byte strobe becomes TLAST.

On the way back in, the receive AXI-Stream carries no start marker. A small tracking flag rebuilds the first-byte strobe. The flag remembers whether the previous accepted beat closed a frame.

For simulation, a loopback MAC model sits behind the bridge. It always accepts transmit beats and replays each one on the receive side one clock later. It also reports the link as up. The transmit AXI-Stream is exported as outputs so that the mapping stays visible. The link speed output is fixed at the 10G code.

Top module: `framed_axis_bridge`

## Requirements
- R1: `axis_tx_tdata`, `axis_tx_tvalid` and `axis_tx_tlast` equal `in_data`, `in_valid` and `in_last` in the same cycle, with no register between them.
- R2: `axis_tx_tuser` equals `in_first` in the same cycle.
- R3: `in_ready` follows the MAC-side transmit ready. The loopback model holds that ready high, so `in_ready` is 1 in every cycle.
- R4: A beat presented with `in_valid` high at a rising edge appears on `out_valid`/`out_data` right after that edge, exactly once. A cycle with `in_valid` low produces `out_valid` low one cycle later, so no beat is lost or duplicated.
- R5: The first valid receive beat after reset has `out_first` high.
- R6: A valid receive beat that follows a beat with `out_last` high has `out_first` high. No other beat has `out_first` high, whatever value `in_first` had when the beat was sent.
- R7: Cycles with `out_valid` low do not change the frame tracking. An idle gap inside a frame does not make the next beat a start, and no strobe is high while idle.
- R8: `out_last` equals the TLAST of the looped-back beat.
- R9: `link_speed` is constant 2'b11, the 10G code.
- R10: `link_up` is constant 1 with the loopback model.
- R11: While `rst_n` is low, `out_valid`, `out_first` and `out_last` are 0, and the tracker returns to expecting a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Transmit byte |
| in_valid | input | 1 | Transmit byte valid |
| in_first | input | 1 | Transmit first byte of frame |
| in_last | input | 1 | Transmit last byte of frame |
| in_ready | output | 1 | Transmit ready (backpressure to source) |
| axis_tx_tdata | output | 8 | MAC-side transmit TDATA |
| axis_tx_tvalid | output | 1 | MAC-side transmit TVALID |
| axis_tx_tlast | output | 1 | MAC-side transmit TLAST |
| axis_tx_tuser | output | 1 | MAC-side transmit TUSER (start of frame) |
| out_data | output | 8 | Receive byte |
| out_valid | output | 1 | Receive byte valid |
| out_first | output | 1 | Receive first byte of frame (regenerated) |
| out_last | output | 1 | Receive last byte of frame |
| link_up | output | 1 | Link status |
| link_speed | output | 2 | Link speed code, 2'b11 = 10G |

## Verification
The transmit mapping is combinational. The bench checks it a moment after driving the inputs on the falling edge, before the next rising edge.

Every receive result is due in the cycle right after the rising edge that captured the transmit beat. The loopback register is the only register on that path, and the start flag acts in the same cycle as the beat. So the bench samples the receive outputs 2 ns after that rising edge and pairs each sample with the beat it drove just before. Reset and idle checks are sampled in the same position, after the edge that applied them.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [1:0] SPEED_10G = 2'b11;

  // Next state of the "expecting start" flag.
  function automatic logic next_expect_start(input logic cur, input logic accepted,
                                             input logic last);
    return accepted ? last : cur;
  endfunction
endpackage

// File: rtl/framed_to_axis.sv
module framed_to_axis #(
  parameter int unsigned DW = bridge_pkg::BYTE_W
) (
  input  logic [DW-1:0] f_data,
  input  logic          f_valid,
  input  logic          f_first,
  input  logic          f_last,
  output logic          f_ready,
  output logic [DW-1:0] m_tdata,
  output logic          m_tvalid,
  output logic          m_tlast,
  output logic          m_tuser,
  input  logic          m_tready
);
  assign m_tdata  = f_data;
  assign m_tvalid = f_valid;
  assign m_tlast  = f_last;
  assign m_tuser  = f_first;
  assign f_ready  = m_tready;
endmodule

// File: rtl/loop_mac.sv
module loop_mac #(
  parameter int unsigned DW = bridge_pkg::BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] tx_tdata,
  input  logic          tx_tvalid,
  input  logic          tx_tlast,
  output logic          tx_tready,
  output logic [DW-1:0] rx_tdata,
  output logic          rx_tvalid,
  output logic          rx_tlast,
  output logic          link_ok
);
  logic tx_accept;
  assign tx_tready = 1'b1;
  assign link_ok   = 1'b1;
  assign tx_accept = tx_tvalid & tx_tready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_tvalid <= 1'b0;
      rx_tlast  <= 1'b0;
      rx_tdata  <= '0;
    end else begin
      rx_tvalid <= tx_accept;
      rx_tlast  <= tx_accept & tx_tlast;
      rx_tdata  <= tx_tdata;
    end
  end

  // R4: an accepted beat comes back exactly one cycle later
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tvalid |=> (rx_tvalid && rx_tdata == $past(tx_tdata)));
  // R4: no phantom beat
  a_r4_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_tvalid |=> !rx_tvalid);
endmodule

// File: rtl/axis_to_framed.sv
module axis_to_framed #(
  parameter int unsigned DW = bridge_pkg::BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] s_tdata,
  input  logic          s_tvalid,
  input  logic          s_tlast,
  output logic [DW-1:0] r_data,
  output logic          r_valid,
  output logic          r_first,
  output logic          r_last
);
  // The receive side has no backpressure, so every valid beat is accepted.
  logic beat_taken;
  logic expect_start;

  assign beat_taken = s_tvalid;

  always_ff @(posedge clk) begin
    if (!rst_n) expect_start <= 1'b1;
    else expect_start <= bridge_pkg::next_expect_start(expect_start, beat_taken, s_tlast);
  end

  assign r_data  = s_tdata;
  assign r_valid = s_tvalid;
  assign r_last  = s_tvalid & s_tlast;
  assign r_first = s_tvalid & expect_start;

  // R6: the beat after a frame-closing beat is a start
  a_r6_first_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_taken && s_tlast) |=> (!s_tvalid || r_first));
  // R7: the beat after a non-closing beat is never a start, gaps included
  a_r7_no_mid_first: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_taken && !s_tlast) |=> !r_first);
endmodule

// File: rtl/framed_axis_bridge.sv
module framed_axis_bridge #(
  parameter int unsigned DW = bridge_pkg::BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic          in_last,
  output logic          in_ready,
  output logic [DW-1:0] axis_tx_tdata,
  output logic          axis_tx_tvalid,
  output logic          axis_tx_tlast,
  output logic          axis_tx_tuser,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          out_first,
  output logic          out_last,
  output logic          link_up,
  output logic [1:0]    link_speed
);
  logic          mac_tx_ready;
  logic [DW-1:0] mac_rx_data;
  logic          mac_rx_valid;
  logic          mac_rx_last;

  framed_to_axis #(.DW(DW)) u_tx (
    .f_data(in_data), .f_valid(in_valid), .f_first(in_first), .f_last(in_last),
    .f_ready(in_ready),
    .m_tdata(axis_tx_tdata), .m_tvalid(axis_tx_tvalid), .m_tlast(axis_tx_tlast),
    .m_tuser(axis_tx_tuser), .m_tready(mac_tx_ready)
  );

  loop_mac #(.DW(DW)) u_mac (
    .clk(clk), .rst_n(rst_n),
    .tx_tdata(axis_tx_tdata), .tx_tvalid(axis_tx_tvalid), .tx_tlast(axis_tx_tlast),
    .tx_tready(mac_tx_ready),
    .rx_tdata(mac_rx_data), .rx_tvalid(mac_rx_valid), .rx_tlast(mac_rx_last),
    .link_ok(link_up)
  );

  axis_to_framed #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .s_tdata(mac_rx_data), .s_tvalid(mac_rx_valid), .s_tlast(mac_rx_last),
    .r_data(out_data), .r_valid(out_valid), .r_first(out_first), .r_last(out_last)
  );

  assign link_speed = bridge_pkg::SPEED_10G;

  // R8: the receive end strobe mirrors the TLAST sent one cycle earlier
  a_r8_last_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == $past(axis_tx_tlast)));
endmodule

// File: tb/framed_axis_bridge_test.sv
module framed_axis_bridge_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic       in_ready;
  logic [7:0] axis_tx_tdata;
  logic       axis_tx_tvalid, axis_tx_tlast, axis_tx_tuser;
  logic [7:0] out_data;
  logic       out_valid, out_first, out_last, link_up;
  logic [1:0] link_speed;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  framed_axis_bridge uut (.*);

  always #4 clk = ~clk;  // 125 MHz

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // stimulus {v,f,l,data} and expected receive {v,f,l,data}
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {3'b110, 8'hA1, 3'b110, 8'hA1},  // R5 first after reset
    {3'b100, 8'hA2, 3'b100, 8'hA2},
    {3'b000, 8'hFF, 3'b000, 8'h00},  // R7 gap mid-frame
    {3'b101, 8'hA3, 3'b101, 8'hA3},  // R8 end
    {3'b000, 8'h00, 3'b000, 8'h00},
    {3'b100, 8'hB0, 3'b110, 8'hB0},  // R6 start rebuilt without in_first
    {3'b111, 8'hB1, 3'b101, 8'hB1},  // R6 in_first ignored mid-frame
    {3'b111, 8'hC0, 3'b111, 8'hC0},  // single-beat frame
    {3'b110, 8'hD0, 3'b110, 8'hD0},
    {3'b000, 8'h00, 3'b000, 8'h00},  // R7
    {3'b000, 8'h00, 3'b000, 8'h00},  // R7
    {3'b101, 8'hD1, 3'b101, 8'hD1}
  };

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 8'hFF);
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin : main
    logic [7:0] lfsr;
    int rcv;
    lfsr = 8'h5A;
    // R11 reset state
    repeat (3) @(posedge clk);
    #2;
    chk("R11 out_valid in reset", out_valid, 0);
    chk("R11 out_first in reset", out_first, 0);
    chk("R11 out_last in reset", out_last, 0);
    chk("R9 link_speed", link_speed, 2'b11);
    chk("R10 link_up", link_up, 1);
    @(negedge clk); rst_n = 1'b1;

    // vector table
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      {in_valid, in_first, in_last, in_data} = VEC[k][21:11];
      #1;
      chk("R1 tdata", axis_tx_tdata, in_data);
      chk("R1 tvalid", axis_tx_tvalid, in_valid);
      chk("R1 tlast", axis_tx_tlast, in_last);
      chk("R2 tuser", axis_tx_tuser, in_first);
      chk("R3 in_ready", in_ready, 1);
      @(posedge clk); #2;
      chk("R4 out_valid", out_valid, VEC[k][10]);
      chk("R6 out_first", out_first, VEC[k][9]);
      chk("R8 out_last", out_last, VEC[k][8]);
      if (VEC[k][10]) chk("R4 out_data", out_data, VEC[k][7:0]);
    end

    // 100-byte frame with pseudo-random source gaps
    rcv = 0;
    for (int idx = 0; idx < 100; ) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      in_valid = !(lfsr[0] & lfsr[1]);
      in_data  = pat(idx);
      in_first = (idx == 0);
      in_last  = (idx == 99);
      if (in_valid) idx++;
      @(posedge clk); #2;
      if (out_valid) begin
        chk("R4 frame byte", out_data, pat(rcv));
        chk("R6 frame first", out_first, rcv == 0);
        chk("R8 frame last", out_last, rcv == 99);
        rcv++;
      end else begin
        chk("R7 gap first low", out_first, 0);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    // idle after the frame: no strobes, no spurious start
    for (int g = 0; g < 5; g++) begin
      @(posedge clk); #2;
      chk("R7 idle valid", out_valid, 0);
      chk("R7 idle first", out_first, 0);
    end
    chk("R4 frame beat count", rcv, 100);

    // reset in mid-frame, then a beat without in_first is a start
    @(negedge clk); in_valid = 1'b1; in_data = 8'h77; in_last = 1'b0;
    @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
    @(posedge clk); #2;
    chk("R11 valid cleared by reset", out_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); in_valid = 1'b1; in_data = 8'h88;
    @(posedge clk); #2;
    chk("R5 first after mid-frame reset", out_first, 1);
    chk("R5 data after reset", out_data, 8'h88);
    @(negedge clk); in_valid = 1'b0;
    chk("R9 link_speed end", link_speed, 2'b11);
    chk("R10 link_up end", link_up, 1);
    done = 1'b1;
    finish_run();
  end
endmodule